// File: doc/BRIEF.md
# Two-Bank SDRAM Command Tracker

This block watches the command bus of a two-bank synchronous DRAM and keeps a cycle-accurate model of what each bank is doing. On every rising clock edge it decodes the chip-select, row-strobe, column-strobe, write-enable and clock-enable pins together with the twelve address lines. It then advances a per-bank state machine through idle, row open, burst read, burst write, auto-precharge bursts, write recovery and precharge.

Each command is checked against the state of the bank it targets and against programmable cycle counts: activate-to-access, activate-to-precharge, precharge duration, bank-to-bank activate spacing, write recovery and burst length. An illegal command changes nothing in the tracker. It produces a one-cycle error pulse with a reason code and the bank concerned. The block is meant to sit beside a memory controller, or in a verification environment, as a protocol monitor.

Top module: `sdt_tracker`

## Requirements
- R1: A command is taken only on an edge where cke is high and cs_n is low. The {ras_n,cas_n,we_n} values are: activate 011, read 101, write 100, precharge 010, refresh 001, mode set 000, burst stop 110, no-op 111. Any edge with cke low or cs_n high acts as a no-op.
- R2: The state codes are idle 0, row open 1, reading 2, writing 3, reading with auto-precharge 4, writing with auto-precharge 5, write recovery 6 and precharging 7. After reset both banks are idle, both open rows are zero and err_valid is low.
- R3: Address bit 11 selects the bank. An accepted activate puts that bank in state 1, and its open_row becomes address bits 10..0 from the next cycle on.
- R4: A read or write to a bank that has no open row (state 0 or 7) raises error code 1.
- R5: An accepted read or write enters state 2 or 3 and lasts cfg_burst cycles, then returns to state 1. Address bit 10 high selects auto-precharge. A read then goes 4 to 7, and a write goes 5 to 6 for cfg_twr cycles and then to 7. Burst stop returns a bank in state 2 or 3 to state 1.
- R6: Read, write, activate or single-bank precharge aimed at a bank in state 4, 5 or 6 raises code 2. So does burst stop while any bank is in state 5.
- R7: Precharge with bit 10 low closes the selected bank; with bit 10 high it closes every open bank. A closed bank stays in state 7 for cfg_trp cycles and then goes idle, and it may be activated cfg_trp cycles after the precharge. An earlier activate raises code 6. An activate to a bank with an open row raises code 3.
- R8: A read or write fewer than cfg_trcd cycles after that bank's activate raises code 4.
- R9: A precharge of an open bank fewer than cfg_tras cycles after its activate raises code 5.
- R10: An activate fewer than cfg_trrd cycles after the previous accepted activate, to either bank, raises code 7.
- R11: Refresh or mode set while any bank is not idle (a bank in its final precharge cycle counts as idle) raises code 8 against the lowest such bank. With both banks idle it is accepted.
- R12: err_valid is high in the cycle after each illegal command only, with err_code and err_bank. An illegal command leaves bank states, open rows and the activate spacing as if a no-op had been issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock enable pin of the bus |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | 12 | Address bus; bit 11 bank, bit 10 auto-precharge / all-banks |
| cfg_burst | input | 4 | Burst duration in cycles |
| cfg_trcd | input | 4 | Activate-to-access minimum, cycles |
| cfg_tras | input | 4 | Activate-to-precharge minimum, cycles |
| cfg_trp | input | 4 | Precharge duration, cycles |
| cfg_twr | input | 4 | Write recovery before auto-precharge, cycles |
| cfg_trrd | input | 4 | Activate-to-activate spacing, cycles |
| bank_state | output | 6 | Three-bit state per bank, bank 0 in bits 2..0 |
| open_row | output | 22 | Eleven-bit row per bank, bank 0 in bits 10..0 |
| err_valid | output | 1 | One-cycle illegal-command pulse |
| err_code | output | 4 | Reason code, zero when no error |
| err_bank | output | 1 | Bank that the error concerns |

## Verification
Every result is due one cycle after the edge that samples its command: the error pulse, the new bank state and the new open row all appear after that edge. Timer-driven transitions land after a counted number of further edges. The bench drives pins on the falling edge and lets one rising edge pass. It compares all outputs on the next falling edge against a bench model that advances by the same single step. The directed sequence places each timing-limit command exactly one cycle before or at its limit, so the expected code follows from counting edges since the activate or precharge.

// File: rtl/sdt_pkg.sv
package sdt_pkg;
  typedef enum logic [2:0] {
    BK_IDLE     = 3'd0,
    BK_ACTIVE   = 3'd1,
    BK_READ     = 3'd2,
    BK_WRITE    = 3'd3,
    BK_READ_AP  = 3'd4,
    BK_WRITE_AP = 3'd5,
    BK_WREC     = 3'd6,
    BK_PRECH    = 3'd7
  } bank_st_e;

  typedef enum logic [2:0] {
    C_NOP, C_ACT, C_READ, C_WRITE, C_PRE, C_REF, C_MRS, C_BST
  } cmd_e;

  localparam logic [3:0] E_NONE     = 4'd0;
  localparam logic [3:0] E_NOT_OPEN = 4'd1;
  localparam logic [3:0] E_AP_BUSY  = 4'd2;
  localparam logic [3:0] E_ROW_OPEN = 4'd3;
  localparam logic [3:0] E_TRCD     = 4'd4;
  localparam logic [3:0] E_TRAS     = 4'd5;
  localparam logic [3:0] E_TRP      = 4'd6;
  localparam logic [3:0] E_TRRD     = 4'd7;
  localparam logic [3:0] E_NOT_IDLE = 4'd8;
endpackage

// File: rtl/sdt_cmd_decode.sv
module sdt_cmd_decode
  import sdt_pkg::*;
(
  input  logic cke,
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e cmd
);
  always_comb begin
    cmd = C_NOP;
    if (cke && !cs_n) begin
      case ({ras_n, cas_n, we_n})
        3'b011:  cmd = C_ACT;
        3'b101:  cmd = C_READ;
        3'b100:  cmd = C_WRITE;
        3'b010:  cmd = C_PRE;
        3'b001:  cmd = C_REF;
        3'b000:  cmd = C_MRS;
        3'b110:  cmd = C_BST;
        default: cmd = C_NOP;
      endcase
    end
  end
endmodule

// File: rtl/sdt_bank.sv
module sdt_bank
  import sdt_pkg::*;
#(
  parameter int TW    = 4,
  parameter int ROW_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go_act,
  input  logic             go_rd,
  input  logic             go_wr,
  input  logic             go_ap,
  input  logic             go_pre,
  input  logic             go_bst,
  input  logic [ROW_W-1:0] row_in,
  input  logic [TW-1:0]    cfg_burst,
  input  logic [TW-1:0]    cfg_twr,
  input  logic [TW-1:0]    cfg_trp,
  input  logic [TW-1:0]    cfg_trcd,
  input  logic [TW-1:0]    cfg_tras,
  output bank_st_e         st,
  output logic [ROW_W-1:0] row_q,
  output logic             ready,
  output logic             is_open,
  output logic             ap_busy,
  output logic             trcd_ok,
  output logic             tras_ok
);
  logic [TW-1:0] tmr;
  logic [TW-1:0] age;
  logic          last;

  assign last    = (tmr <= TW'(1));
  assign is_open = (st == BK_ACTIVE) || (st == BK_READ) || (st == BK_WRITE);
  assign ap_busy = (st == BK_READ_AP) || (st == BK_WRITE_AP) || (st == BK_WREC);
  assign ready   = (st == BK_IDLE) || ((st == BK_PRECH) && last);
  assign trcd_ok = (age >= cfg_trcd);
  assign tras_ok = (age >= cfg_tras);

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= BK_IDLE;
      tmr   <= '0;
      age   <= '0;
      row_q <= '0;
    end else begin
      if (age != '1) age <= age + TW'(1);
      if (go_act) begin
        st    <= BK_ACTIVE;
        row_q <= row_in;
        age   <= TW'(1);
      end else if (go_rd || go_wr) begin
        if (go_rd) st <= go_ap ? BK_READ_AP : BK_READ;
        else       st <= go_ap ? BK_WRITE_AP : BK_WRITE;
        tmr <= cfg_burst;
      end else if (go_pre && is_open) begin
        st  <= BK_PRECH;
        tmr <= cfg_trp;
      end else if (go_bst && ((st == BK_READ) || (st == BK_WRITE))) begin
        st <= BK_ACTIVE;
      end else begin
        case (st)
          BK_READ, BK_WRITE: begin
            if (last) st <= BK_ACTIVE;
            else      tmr <= tmr - TW'(1);
          end
          BK_READ_AP: begin
            if (last) begin st <= BK_PRECH; tmr <= cfg_trp; end
            else tmr <= tmr - TW'(1);
          end
          BK_WRITE_AP: begin
            if (last) begin st <= BK_WREC; tmr <= cfg_twr; end
            else tmr <= tmr - TW'(1);
          end
          BK_WREC: begin
            if (last) begin st <= BK_PRECH; tmr <= cfg_trp; end
            else tmr <= tmr - TW'(1);
          end
          BK_PRECH: begin
            if (last) st <= BK_IDLE;
            else      tmr <= tmr - TW'(1);
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/sdt_rules.sv
module sdt_rules
  import sdt_pkg::*;
#(
  parameter int NB = 2,
  parameter int BW = 1
) (
  input  cmd_e          cmd,
  input  logic [BW-1:0] sel,
  input  logic          all_sel,
  input  logic [NB-1:0] ready,
  input  logic [NB-1:0] is_open,
  input  logic [NB-1:0] ap_busy,
  input  logic [NB-1:0] wr_ap,
  input  logic [NB-1:0] trcd_ok,
  input  logic [NB-1:0] tras_ok,
  input  logic          rrd_ok,
  output logic          ok,
  output logic [3:0]    code,
  output logic [BW-1:0] ebank
);
  always_comb begin
    code  = E_NONE;
    ebank = sel;
    case (cmd)
      C_ACT: begin
        if (ap_busy[sel])      code = E_AP_BUSY;
        else if (is_open[sel]) code = E_ROW_OPEN;
        else if (!ready[sel])  code = E_TRP;
        else if (!rrd_ok)      code = E_TRRD;
      end
      C_READ, C_WRITE: begin
        if (ap_busy[sel])       code = E_AP_BUSY;
        else if (!is_open[sel]) code = E_NOT_OPEN;
        else if (!trcd_ok[sel]) code = E_TRCD;
      end
      C_PRE: begin
        if (all_sel) begin
          for (int i = NB - 1; i >= 0; i--) begin
            if (ap_busy[i]) begin
              code = E_AP_BUSY; ebank = BW'(i);
            end else if (is_open[i] && !tras_ok[i]) begin
              code = E_TRAS; ebank = BW'(i);
            end
          end
        end else if (ap_busy[sel]) begin
          code = E_AP_BUSY;
        end else if (is_open[sel] && !tras_ok[sel]) begin
          code = E_TRAS;
        end
      end
      C_REF, C_MRS: begin
        for (int i = NB - 1; i >= 0; i--) begin
          if (!ready[i]) begin code = E_NOT_IDLE; ebank = BW'(i); end
        end
      end
      C_BST: begin
        for (int i = NB - 1; i >= 0; i--) begin
          if (wr_ap[i]) begin code = E_AP_BUSY; ebank = BW'(i); end
        end
      end
      default: ;
    endcase
    ok = (code == E_NONE);
  end
endmodule

// File: rtl/sdt_tracker.sv
module sdt_tracker
  import sdt_pkg::*;
#(
  parameter int NB     = 2,
  parameter int ROW_W  = 11,
  parameter int AP_BIT = 10,
  parameter int TW     = 4,
  localparam int BW     = $clog2(NB),
  localparam int ADDR_W = ROW_W + BW,
  localparam int SW     = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cke,
  input  logic                cs_n,
  input  logic                ras_n,
  input  logic                cas_n,
  input  logic                we_n,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [TW-1:0]       cfg_burst,
  input  logic [TW-1:0]       cfg_trcd,
  input  logic [TW-1:0]       cfg_tras,
  input  logic [TW-1:0]       cfg_trp,
  input  logic [TW-1:0]       cfg_twr,
  input  logic [TW-1:0]       cfg_trrd,
  output logic [NB*SW-1:0]    bank_state,
  output logic [NB*ROW_W-1:0] open_row,
  output logic                err_valid,
  output logic [3:0]          err_code,
  output logic [BW-1:0]       err_bank
);
  cmd_e          cmd;
  logic [BW-1:0] sel;
  logic          ap;
  logic [NB-1:0] ready, is_open, ap_busy, wr_ap, trcd_ok, tras_ok;
  logic          ok;
  logic [3:0]    code;
  logic [BW-1:0] ebank;
  logic [TW-1:0] rrd_age;

  assign sel = addr[ROW_W +: BW];
  assign ap  = addr[AP_BIT];

  sdt_cmd_decode u_dec (
    .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .cmd(cmd)
  );

  sdt_rules #(.NB(NB), .BW(BW)) u_rules (
    .cmd(cmd), .sel(sel), .all_sel(ap), .ready(ready), .is_open(is_open),
    .ap_busy(ap_busy), .wr_ap(wr_ap), .trcd_ok(trcd_ok), .tras_ok(tras_ok),
    .rrd_ok(rrd_age >= cfg_trrd), .ok(ok), .code(code), .ebank(ebank)
  );

  for (genvar g = 0; g < NB; g++) begin : g_bank
    bank_st_e st;
    logic     hit;
    assign hit = ok && (sel == BW'(g));
    sdt_bank #(.TW(TW), .ROW_W(ROW_W)) u_bank (
      .clk(clk), .rst(rst),
      .go_act(hit && (cmd == C_ACT)),
      .go_rd(hit && (cmd == C_READ)),
      .go_wr(hit && (cmd == C_WRITE)),
      .go_ap(ap),
      .go_pre(ok && (cmd == C_PRE) && (ap || (sel == BW'(g)))),
      .go_bst(ok && (cmd == C_BST)),
      .row_in(addr[ROW_W-1:0]),
      .cfg_burst(cfg_burst), .cfg_twr(cfg_twr), .cfg_trp(cfg_trp),
      .cfg_trcd(cfg_trcd), .cfg_tras(cfg_tras),
      .st(st), .row_q(open_row[g*ROW_W +: ROW_W]),
      .ready(ready[g]), .is_open(is_open[g]), .ap_busy(ap_busy[g]),
      .trcd_ok(trcd_ok[g]), .tras_ok(tras_ok[g])
    );
    assign wr_ap[g] = (st == BK_WRITE_AP);
    assign bank_state[g*SW +: SW] = st;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rrd_age   <= '1;
      err_valid <= 1'b0;
      err_code  <= E_NONE;
      err_bank  <= '0;
    end else begin
      if (ok && (cmd == C_ACT))  rrd_age <= TW'(1);
      else if (rrd_age != '1)    rrd_age <= rrd_age + TW'(1);
      err_valid <= !ok;
      err_code  <= code;
      err_bank  <= ok ? '0 : ebank;
    end
  end
endmodule

// File: rtl/sdt_tracker_chk.sv
module sdt_tracker_chk
  import sdt_pkg::*;
#(
  parameter int NB    = 2,
  parameter int ROW_W = 11,
  localparam int BW     = $clog2(NB),
  localparam int ADDR_W = ROW_W + BW
) (
  input logic                clk,
  input logic                rst,
  input logic                cke,
  input logic                cs_n,
  input logic                ras_n,
  input logic                cas_n,
  input logic                we_n,
  input logic [ADDR_W-1:0]   addr,
  input logic [NB*3-1:0]     bank_state,
  input logic [NB*ROW_W-1:0] open_row,
  input logic                err_valid,
  input logic [3:0]          err_code
);
  logic rd_cmd, ref_cmd;
  assign rd_cmd  = cke && !cs_n && ras_n && !cas_n && we_n;
  assign ref_cmd = cke && !cs_n && !ras_n && !cas_n && we_n;

  p_code_range_r12: assert property (@(posedge clk) disable iff (rst)
    err_valid |-> (err_code != 4'd0) && (err_code <= 4'd8));

  p_row_hold_r12: assert property (@(posedge clk) disable iff (rst)
    err_valid |-> $stable(open_row));

  p_ref_busy_r11: assert property (@(posedge clk) disable iff (rst)
    (ref_cmd && (bank_state[2:0] == BK_ACTIVE)) |=> (err_valid && (err_code == 4'd8)));

  for (genvar g = 0; g < NB; g++) begin : g_chk
    p_row_on_act_r3: assert property (@(posedge clk) disable iff (rst)
      (open_row[g*ROW_W +: ROW_W] != $past(open_row[g*ROW_W +: ROW_W]))
        |-> (bank_state[g*3 +: 3] == BK_ACTIVE));

    p_rd_idle_r4: assert property (@(posedge clk) disable iff (rst)
      (rd_cmd && (addr[ROW_W +: BW] == BW'(g)) && (bank_state[g*3 +: 3] == BK_IDLE))
        |=> (err_valid && (err_code == 4'd1)));

    p_prech_exit_r7: assert property (@(posedge clk) disable iff (rst)
      (bank_state[g*3 +: 3] == BK_PRECH)
        |=> (bank_state[g*3 +: 3] inside {BK_PRECH, BK_IDLE, BK_ACTIVE}));

    p_wap_path_r5: assert property (@(posedge clk) disable iff (rst)
      (bank_state[g*3 +: 3] == BK_WRITE_AP)
        |=> (bank_state[g*3 +: 3] inside {BK_WRITE_AP, BK_WREC}));
  end
endmodule

bind sdt_tracker sdt_tracker_chk #(.NB(NB), .ROW_W(ROW_W)) u_chk (.*);

// File: tb/tb_sdt_tracker.sv
module tb_sdt_tracker;
  localparam int CLK_P = 10;
  localparam int BURST = 4, TRCD = 2, TRAS = 5, TRP = 3, TWR = 2, TRRD = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [11:0] addr = '0;
  logic [5:0]  bank_state;
  logic [21:0] open_row;
  logic        err_valid;
  logic [3:0]  err_code;
  logic        err_bank;

  int checks = 0, failures = 0;
  int m_st[2], m_tmr[2], m_age[2], m_row[2], m_rrd;
  int e_ev, e_code, e_bank;

  always #(CLK_P/2) clk = ~clk;

  sdt_tracker dut (
    .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .addr(addr), .cfg_burst(4'(BURST)), .cfg_trcd(4'(TRCD)),
    .cfg_tras(4'(TRAS)), .cfg_trp(4'(TRP)), .cfg_twr(4'(TWR)), .cfg_trrd(4'(TRRD)),
    .bank_state(bank_state), .open_row(open_row), .err_valid(err_valid),
    .err_code(err_code), .err_bank(err_bank)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit f_open(int i); return m_st[i] >= 1 && m_st[i] <= 3; endfunction
  function automatic bit f_apb(int i);  return m_st[i] >= 4 && m_st[i] <= 6; endfunction
  function automatic bit f_rdy(int i);  return m_st[i] == 0 || (m_st[i] == 7 && m_tmr[i] <= 1); endfunction

  // Reference step: expected outputs after the coming edge (R1..R12)
  task automatic model(input bit ck, input bit cs, input bit ra, input bit ca,
                       input bit we, input bit [11:0] a);
    int cmd = 0;
    int b = int'(a[11]);
    int ap = int'(a[10]);
    int code = 0;
    int eb = b;
    if (ck && !cs) begin
      case ({ra, ca, we})
        3'b011: cmd = 1; 3'b101: cmd = 2; 3'b100: cmd = 3; 3'b010: cmd = 4;
        3'b001: cmd = 5; 3'b000: cmd = 6; 3'b110: cmd = 7; default: cmd = 0;
      endcase
    end
    case (cmd)
      1: if (f_apb(b)) code = 2; else if (f_open(b)) code = 3;
         else if (!f_rdy(b)) code = 6; else if (m_rrd < TRRD) code = 7;
      2, 3: if (f_apb(b)) code = 2; else if (!f_open(b)) code = 1;
         else if (m_age[b] < TRCD) code = 4;
      4: if (ap == 1) begin
           for (int i = 1; i >= 0; i--) begin
             if (f_apb(i)) begin code = 2; eb = i; end
             else if (f_open(i) && m_age[i] < TRAS) begin code = 5; eb = i; end
           end
         end else if (f_apb(b)) code = 2;
         else if (f_open(b) && m_age[b] < TRAS) code = 5;
      5, 6: for (int i = 1; i >= 0; i--) if (!f_rdy(i)) begin code = 8; eb = i; end
      7: for (int i = 1; i >= 0; i--) if (m_st[i] == 5) begin code = 2; eb = i; end
      default: ;
    endcase
    e_ev = (code != 0); e_code = code; e_bank = (code != 0) ? eb : 0;
    if (code == 0 && cmd == 1) m_rrd = 1; else if (m_rrd < 15) m_rrd++;
    for (int i = 0; i < 2; i++) begin
      bit ok = (code == 0);
      if (m_age[i] < 15) m_age[i]++;
      if (ok && cmd == 1 && b == i) begin
        m_st[i] = 1; m_row[i] = int'(a[10:0]); m_age[i] = 1;
      end else if (ok && (cmd == 2 || cmd == 3) && b == i) begin
        m_st[i] = (cmd == 2) ? (ap == 1 ? 4 : 2) : (ap == 1 ? 5 : 3);
        m_tmr[i] = BURST;
      end else if (ok && cmd == 4 && (ap == 1 || b == i) && f_open(i)) begin
        m_st[i] = 7; m_tmr[i] = TRP;
      end else if (ok && cmd == 7 && (m_st[i] == 2 || m_st[i] == 3)) begin
        m_st[i] = 1;
      end else begin
        case (m_st[i])
          2, 3: if (m_tmr[i] <= 1) m_st[i] = 1; else m_tmr[i]--;
          4: if (m_tmr[i] <= 1) begin m_st[i] = 7; m_tmr[i] = TRP; end else m_tmr[i]--;
          5: if (m_tmr[i] <= 1) begin m_st[i] = 6; m_tmr[i] = TWR; end else m_tmr[i]--;
          6: if (m_tmr[i] <= 1) begin m_st[i] = 7; m_tmr[i] = TRP; end else m_tmr[i]--;
          7: if (m_tmr[i] <= 1) m_st[i] = 0; else m_tmr[i]--;
          default: ;
        endcase
      end
    end
  endtask

  // kind: 0 nop,1 act,2 read,3 write,4 pre,5 ref,6 mrs,7 bst,8 deselect
  task automatic op(input int kind, input bit b, input bit a10,
                    input bit [10:0] row, input bit ck = 1'b1);
    bit [2:0] p;
    case (kind)
      1: p = 3'b011; 2: p = 3'b101; 3: p = 3'b100; 4: p = 3'b010;
      5: p = 3'b001; 6: p = 3'b000; 7: p = 3'b110; default: p = 3'b111;
    endcase
    cke = ck; cs_n = (kind == 8); {ras_n, cas_n, we_n} = p;
    addr = {b, row};
    if (kind != 1) addr[10] = a10;
    model(cke, cs_n, ras_n, cas_n, we_n, addr);
    @(posedge clk);
    @(negedge clk);
    check("R5 state bank0", int'(bank_state[2:0]), m_st[0]);
    check("R5 state bank1", int'(bank_state[5:3]), m_st[1]);
    check("R3 open row bank0", int'(open_row[10:0]), m_row[0]);
    check("R3 open row bank1", int'(open_row[21:11]), m_row[1]);
    check("R12 err_valid", int'(err_valid), e_ev);
    check("R12 err_code", int'(err_code), e_code);
    check("R12 err_bank", int'(err_bank), e_bank);
  endtask

  task automatic nops(input int n);
    for (int i = 0; i < n; i++) op(0, 1'b0, 1'b0, 11'd0);
  endtask

  initial begin
    #(CLK_P * 200000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 2; i++) begin m_st[i] = 0; m_tmr[i] = 0; m_age[i] = 0; m_row[i] = 0; end
    m_rrd = 15;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R2: reset state
    check("R2 reset states", int'(bank_state), 0);
    check("R2 reset err", int'(err_valid), 0);
    check("R2 reset rows", int'(open_row), 0);

    op(2, 0, 0, 11'h003);                check("R4 read idle code", int'(err_code), 1);
    op(1, 0, 0, 11'h155, 1'b0);          check("R1 cke low ignored", int'(bank_state[2:0]), 0);
    check("R1 cke low no error", int'(err_valid), 0);
    op(1, 0, 0, 11'h155);                check("R3 act state", int'(bank_state[2:0]), 1);
    check("R3 act row", int'(open_row[10:0]), 'h155);
    op(1, 1, 0, 11'h2AA);                check("R10 trrd code", int'(err_code), 7);
    check("R10 trrd bank", int'(err_bank), 1);
    op(1, 1, 0, 11'h2AA);                check("R10 act after spacing", int'(bank_state[5:3]), 1);
    op(2, 1, 0, 11'h001);                check("R8 trcd code", int'(err_code), 4);
    op(4, 0, 0, 11'h000);                check("R9 tras code", int'(err_code), 5);
    check("R12 illegal pre keeps bank", int'(bank_state[2:0]), 1);
    op(1, 0, 0, 11'h011);                check("R7 act open code", int'(err_code), 3);
    check("R12 illegal act keeps row", int'(open_row[10:0]), 'h155);
    op(2, 0, 1, 11'h004);                check("R5 read ap state", int'(bank_state[2:0]), 4);
    op(3, 0, 0, 11'h004);                check("R6 ap busy code", int'(err_code), 2);
    nops(3);                             check("R5 read ap to precharge", int'(bank_state[2:0]), 7);
    nops(1);
    op(1, 0, 0, 11'h077);                check("R7 early act code", int'(err_code), 6);
    op(5, 0, 0, 11'h000);                check("R11 ref busy code", int'(err_code), 8);
    check("R11 ref busy bank", int'(err_bank), 1);
    op(4, 0, 1, 11'h000);                check("R7 precharge all", int'(bank_state[5:3]), 7);
    nops(2);
    op(5, 0, 0, 11'h000);                check("R11 ref legal", int'(err_valid), 0);
    check("R11 banks idle", int'(bank_state), 0);
    op(1, 0, 0, 11'h0F0); nops(1);
    op(3, 0, 1, 11'h008);                check("R5 write ap state", int'(bank_state[2:0]), 5);
    nops(4);                             check("R5 write recovery", int'(bank_state[2:0]), 6);
    nops(2);                             check("R5 write ap precharge", int'(bank_state[2:0]), 7);
    nops(3);                             check("R7 precharge to idle", int'(bank_state[2:0]), 0);
    op(1, 1, 0, 11'h001); nops(1);
    op(3, 1, 0, 11'h002);                check("R5 write state", int'(bank_state[5:3]), 3);
    op(7, 0, 0, 11'h000);                check("R5 burst stop", int'(bank_state[5:3]), 1);

    // constrained random traffic, compared cycle by cycle with the model
    void'($urandom(32'h5D7A11));
    for (int n = 0; n < 3000; n++) begin
      int r = int'($urandom_range(0, 99));
      int k;
      if (r < 30)      k = 0;
      else if (r < 45) k = 1;
      else if (r < 60) k = 2;
      else if (r < 72) k = 3;
      else if (r < 84) k = 4;
      else if (r < 88) k = 5;
      else if (r < 90) k = 6;
      else if (r < 95) k = 7;
      else             k = 8;
      op(k, 1'($urandom()), ($urandom_range(0, 3) == 0),
         11'($urandom()), ($urandom_range(0, 19) != 0));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule